// File: doc/BRIEF.md
# Store Queue with Read-Miss Bypass

This block sits between a write-through cache and a slow main memory. Every store the processor issues is pushed into a small circular queue of address/data pairs. Once the queue takes the entry, the processor treats the store as finished. The processor is held back only when every slot is occupied. In the background, a single memory port retires the queued writes one at a time, oldest first.

A read miss does not wait for the queue to empty. Its word address is compared at once against every occupied slot.

- If no slot holds that address, the read takes the memory port ahead of the pending writes.
- If one or more slots hold it, the data of the most recently queued matching store is returned in the same cycle. Memory is not touched, and the port stays free for draining.

Top module: `wbuf_bypass`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `st_ready` is 1, `mem_req` is 0 and `rd_done` is 0.
- R2: When no read miss needs the port and at least one entry is queued, the port presents the oldest entry: `mem_req`=1, `mem_we`=1, `mem_addr`/`mem_wdata` equal to that entry. The entry leaves the queue in a cycle where `mem_gnt` is 1, and entries leave in arrival order.
- R3: With DEPTH (4) entries held and no drain completing in the cycle, `st_ready` is 0. A store presented then is not stored and never reaches memory.
- R4: With DEPTH entries held, a cycle in which a drain completes (`mem_gnt`=1 on a write) has `st_ready`=1, and a store presented then is queued behind the remaining entries.
- R5: A read miss (`rd_valid`=1) whose address matches no queued entry makes the port present a read (`mem_req`=1, `mem_we`=0, `mem_addr`=`rd_addr`), even with writes queued. `rd_done` then equals `mem_gnt`, with `rd_data`=`mem_rdata` and `rd_fwd`=0. Only entries already queued are compared, not a store presented in the same cycle.
- R6: A read miss whose address matches a queued entry gets `rd_done`=1 and `rd_fwd`=1 in that cycle, with `rd_data` equal to the data of the youngest matching entry. The port is not used for a read in that cycle.
- R7: Addresses are word addresses compared over all ADDR_W (32) bits. Entries differing from `rd_addr` in any bit, including bit 31, do not match.
- R8: With the queue empty and no read miss presented, `mem_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store presented |
| st_addr | input | 32 | Store word address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store accepted this cycle when high |
| rd_valid | input | 1 | Read miss presented, held until `rd_done` |
| rd_addr | input | 32 | Read miss word address |
| rd_done | output | 1 | Read miss answered this cycle |
| rd_data | output | 32 | Read result |
| rd_fwd | output | 1 | Result came from a queued store |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | 1 = write (drain), 0 = read |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Write data for a drain |
| mem_gnt | input | 1 | Memory completes the presented operation this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_gnt` on a read |

## Verification
The assertions assume a processor that holds `rd_valid` and `rd_addr` steady until `rd_done`. They also assume it never presents a store and a read miss to the same word in the same cycle, since only already-queued entries are compared. The stimulus keeps to both rules: it keeps an outstanding read frozen until completion, and it drops any store whose address equals the read being presented. Addresses come from a pool of eight values that includes pairs differing only in bit 31. Grant patterns alternate between long stalls, which fill the queue, and free-running phases, which exercise the full-with-drain case.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
   typedef enum logic [1:0] {
      MP_IDLE  = 2'd0,
      MP_DRAIN = 2'd1,
      MP_READ  = 2'd2
   } mport_op_e;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [AW-1:0]                push_addr,
   input  logic [DW-1:0]                push_data,
   input  logic                         pop,
   output logic [DEPTH-1:0][AW-1:0]     slot_addr,
   output logic [DEPTH-1:0][DW-1:0]     slot_data,
   output logic [PW-1:0]                head_ptr,
   output logic [CW-1:0]                count,
   output logic [AW-1:0]                head_addr,
   output logic [DW-1:0]                head_data,
   output logic                         full,
   output logic                         empty
);
   logic [DEPTH-1:0][AW-1:0] addr_q;
   logic [DEPTH-1:0][DW-1:0] data_q;
   logic [PW-1:0]            wp_q, rp_q;
   logic [CW-1:0]            cnt_q;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("wbuf_fifo: DEPTH must be a power of two >= 2");
      assert (AW >= 1 && DW >= 1)
         else $error("wbuf_fifo: widths must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         wp_q   <= '0;
         rp_q   <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) begin
            addr_q[wp_q] <= push_addr;
            data_q[wp_q] <= push_data;
            wp_q         <= wp_q + 1'b1;
         end
         if (pop) begin
            rp_q <= rp_q + 1'b1;
         end
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign slot_addr = addr_q;
   assign slot_data = data_q;
   assign head_ptr  = rp_q;
   assign count     = cnt_q;
   assign head_addr = addr_q[rp_q];
   assign head_data = data_q[rp_q];
   assign full      = (cnt_q == CW'(DEPTH));
   assign empty     = (cnt_q == '0);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));
   assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (count == $past(count) + 1'b1));
   assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic [DEPTH-1:0][AW-1:0] slot_addr,
   input  logic [DEPTH-1:0][DW-1:0] slot_data,
   input  logic [PW-1:0]            head_ptr,
   input  logic [CW-1:0]            count,
   input  logic [AW-1:0]            q_addr,
   output logic                     hit,
   output logic [DW-1:0]            hit_data
);
   logic [DEPTH-1:0] eq;

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_cmp
         assign eq[gi] = (slot_addr[gi] == q_addr);
      end
   endgenerate

   // Walk from oldest to youngest; a later match overrides, so the youngest wins.
   always_comb begin
      logic [PW-1:0] s;
      hit      = 1'b0;
      hit_data = '0;
      s        = '0;
      for (int k = 0; k < DEPTH; k++) begin
         s = head_ptr + PW'(k);
         if (CW'(k) < count && eq[s]) begin
            hit      = 1'b1;
            hit_data = slot_data[s];
         end
      end
   end
endmodule

// File: rtl/wbuf_arb.sv
module wbuf_arb
   import wbuf_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_need,
   input  logic [AW-1:0] rd_addr,
   input  logic          drain_ok,
   input  logic [AW-1:0] head_addr,
   input  logic [DW-1:0] head_data,
   input  logic          mem_gnt,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          pop,
   output logic          rd_mem_done
);
   mport_op_e op;

   always_comb begin
      if (rd_need)       op = MP_READ;
      else if (drain_ok) op = MP_DRAIN;
      else               op = MP_IDLE;
   end

   always_comb begin
      mem_req     = (op != MP_IDLE);
      mem_we      = (op == MP_DRAIN);
      mem_addr    = (op == MP_READ) ? rd_addr : head_addr;
      mem_wdata   = (op == MP_DRAIN) ? head_data : '0;
      pop         = (op == MP_DRAIN) && mem_gnt;
      rd_mem_done = (op == MP_READ) && mem_gnt;
   end

   assert_read_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_need && drain_ok) |-> (mem_req && !mem_we && !pop));
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_need && !drain_ok) |-> !mem_req);
   assert_one_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({pop, rd_mem_done}) <= 1);
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_valid,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   output logic          st_ready,
   input  logic          rd_valid,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_done,
   output logic [DW-1:0] rd_data,
   output logic          rd_fwd,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_gnt,
   input  logic [DW-1:0] mem_rdata
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   logic [DEPTH-1:0][AW-1:0] slot_addr;
   logic [DEPTH-1:0][DW-1:0] slot_data;
   logic [PW-1:0]            head_ptr;
   logic [CW-1:0]            count;
   logic [AW-1:0]            head_addr;
   logic [DW-1:0]            head_data;
   logic                     full, empty, push, pop;
   logic                     hit, rd_need, rd_mem_done;
   logic [DW-1:0]            hit_data;

   wbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_addr(st_addr), .push_data(st_data),
      .pop(pop),
      .slot_addr(slot_addr), .slot_data(slot_data),
      .head_ptr(head_ptr), .count(count),
      .head_addr(head_addr), .head_data(head_data),
      .full(full), .empty(empty)
   );

   wbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
      .slot_addr(slot_addr), .slot_data(slot_data),
      .head_ptr(head_ptr), .count(count),
      .q_addr(rd_addr), .hit(hit), .hit_data(hit_data)
   );

   assign rd_need = rd_valid && !hit;

   wbuf_arb #(.AW(AW), .DW(DW)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .rd_need(rd_need), .rd_addr(rd_addr),
      .drain_ok(!empty), .head_addr(head_addr), .head_data(head_data),
      .mem_gnt(mem_gnt),
      .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .pop(pop), .rd_mem_done(rd_mem_done)
   );

   assign st_ready = !full || pop;
   assign push     = st_valid && st_ready;
   assign rd_fwd   = rd_valid && hit;
   assign rd_done  = rd_fwd || rd_mem_done;
   assign rd_data  = hit ? hit_data : mem_rdata;

   assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !(mem_req && mem_we && mem_gnt)) |-> !st_ready);
   assert_full_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_gnt) |-> st_ready);
   assert_fwd_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fwd |-> (rd_done && !(mem_req && !mem_we)));
   assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_done) |=> (rd_valid && $stable(rd_addr)));
   assert_empty_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> !rd_fwd);
endmodule

// File: tb/wbuf_bypass_test.sv
module wbuf_bypass_test;
   localparam int DEPTH = 4;
   localparam logic [31:0] RK = 32'h5A5A_0F0F;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        st_valid, rd_valid, mem_gnt;
   logic [31:0] st_addr, st_data, rd_addr;
   logic        st_ready, rd_done, rd_fwd, mem_req, mem_we;
   logic [31:0] rd_data, mem_addr, mem_wdata, mem_rdata;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   assign mem_rdata = mem_addr ^ RK;

   wbuf_bypass uut (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_done(rd_done),
      .rd_data(rd_data), .rd_fwd(rd_fwd),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pool(input logic [2:0] i);
      case (i)
         3'd0: pool = 32'h0000_0000;
         3'd1: pool = 32'h0000_0001;
         3'd2: pool = 32'h0000_0002;
         3'd3: pool = 32'h8000_0002;
         3'd4: pool = 32'h0000_0003;
         3'd5: pool = 32'hFFFF_FFFF;
         3'd6: pool = 32'h7FFF_FFFF;
         default: pool = 32'h8000_0000;
      endcase
   endfunction

   // reference queue, index 0 = oldest
   logic [31:0] qa [DEPTH];
   logic [31:0] qd [DEPTH];
   int          qn = 0;
   logic [31:0] lf = 32'h1ACE_B00C;
   logic        rd_pend = 1'b0;

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; st_valid = 1'b0; rd_valid = 1'b0; mem_gnt = 1'b0;
      st_addr = '0; st_data = '0; rd_addr = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 st_ready in reset", {31'd0, st_ready}, 32'd1);
      chk("R1 mem_req in reset", {31'd0, mem_req}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 st_ready", {31'd0, st_ready}, 32'd1);
      chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
      chk("R1 rd_done", {31'd0, rd_done}, 32'd0);

      for (int cyc = 0; cyc < 8000; cyc++) begin
         int          mode;
         logic        m, twin, rneed, drain, e_ready, e_done, e_req;
         logic [31:0] md;
         mode = (cyc / 1000) % 4;
         @(negedge clk);
         lf = {lf[30:0], 1'b0} ^ (lf[31] ? 32'h04C1_1DB7 : 32'h0);
         case (mode)
            0: mem_gnt = lf[0];
            1: mem_gnt = (cyc % 64) >= 40;
            2: mem_gnt = 1'b1;
            default: mem_gnt = lf[0] & lf[1];
         endcase
         st_valid = lf[3] | lf[2] | (mode == 1);
         st_addr  = pool(lf[6:4]);
         st_data  = cyc * 32'h0001_0003 + 32'h11;
         if (!rd_pend) begin
            rd_valid = lf[9] & (lf[10] | (mode == 2));
            rd_addr  = pool(lf[13:11]);
         end
         if (rd_valid && st_valid && st_addr == rd_addr) st_valid = 1'b0;
         #1;
         m = 1'b0; twin = 1'b0; md = '0;
         for (int k = 0; k < qn; k++) begin
            if (qa[k] == rd_addr) begin m = 1'b1; md = qd[k]; end
            if (qa[k] == (rd_addr ^ 32'h8000_0000)) twin = 1'b1;
         end
         rneed   = rd_valid && !m;
         e_req   = rneed || (qn > 0);
         drain   = mem_gnt && !rneed && (qn > 0);
         e_ready = (qn < DEPTH) || drain;
         e_done  = rd_valid && (m || mem_gnt);

         if (qn == DEPTH && drain) chk("R4 st_ready when full with drain", {31'd0, st_ready}, 32'd1);
         else chk("R3 st_ready", {31'd0, st_ready}, {31'd0, e_ready});
         if (qn == 0 && !rd_valid) chk("R8 idle mem_req", {31'd0, mem_req}, 32'd0);
         else chk("R2 mem_req", {31'd0, mem_req}, {31'd0, e_req});
         if (rneed) begin
            chk("R5 read op mem_we", {31'd0, mem_we}, 32'd0);
            chk("R5 read mem_addr", mem_addr, rd_addr);
         end else if (qn > 0) begin
            chk("R2 drain mem_we", {31'd0, mem_we}, 32'd1);
            chk("R2 drain mem_addr", mem_addr, qa[0]);
            chk("R2 drain mem_wdata", mem_wdata, qd[0]);
         end
         if (rd_valid) begin
            chk(twin && !m ? "R7 rd_done" : (m ? "R6 rd_done" : "R5 rd_done"),
                {31'd0, rd_done}, {31'd0, e_done});
            chk(twin && !m ? "R7 rd_fwd" : (m ? "R6 rd_fwd" : "R5 rd_fwd"),
                {31'd0, rd_fwd}, {31'd0, m});
            if (e_done)
               chk(m ? "R6 forwarded data" : "R5 memory data", rd_data, m ? md : (rd_addr ^ RK));
         end

         if (drain) begin
            for (int k = 0; k < DEPTH - 1; k++) begin
               qa[k] = qa[k+1];
               qd[k] = qd[k+1];
            end
            qn--;
         end
         if (st_valid && e_ready) begin
            qa[qn] = st_addr;
            qd[qn] = st_data;
            qn++;
         end
         rd_pend = rd_valid && !e_done;
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule